// File: doc/BRIEF.md
# Data-Acquisition Card Host Register Front End

This block sits between an 8-bit host I/O bus and the conversion and timing hardware of a plug-in acquisition card. It claims a window of eight consecutive I/O addresses. Seven switch inputs set the upper address bits of that window, so it can be placed on any 8-byte boundary. The setting `base_sw = 7'h60` gives the usual window at 0x300 to 0x307. Inside the window, a read and a write at the same offset do different things. Writes at the two lowest offsets start a conversion, and reads at those offsets return the stored result in two bytes.

A started conversion marks the block busy and sends a one-cycle start pulse to the converter, with a resolution select beside it. The converter returns its result on a valid/ready stream. `res_ready` is high exactly while a conversion is outstanding. A result offered while `res_ready` is low is not taken, and the converter must hold `res_valid` and `res_data` steady until a cycle in which both are high. The upper four offsets are passed through to an external three-counter timer. The block does not time, convert or buffer anything itself.

Host reads are combinational within the strobe cycle. Host writes take effect at the clock edge that samples `bus_wr`.

Top module: `daq_regif`

## Requirements
- R1: The block responds only when `bus_addr[9:3]` equals `base_sw`. Outside that window, `bus_oe` stays low, `bus_rdata` is 0x00, and a write changes no register and raises no strobe.
- R2: A read of offset 0 returns {result[3:0], channel[3:0]}. A read of offset 1 returns result[11:4].
- R3: A read of offset 2 returns {busy, error, 2'b00, control[3:0]}. A read of offset 3 returns {busy, error, 2'b00, gain[3:0]}. Busy is bit 7 and error is bit 6.
- R4: A write to offset 0 starts an 8-bit conversion (`adc_hi_res`=0), and a write to offset 1 starts a 12-bit conversion (`adc_hi_res`=1). `adc_start` is high for exactly the one cycle after the write edge. Busy is set from that same cycle, and control[3:0] is latched as the channel number.
- R5: `res_ready` equals busy. On the edge where `res_valid` and `res_ready` are both high, the result is stored and busy clears. An 8-bit conversion stores result bits 3:0 as zero.
- R6: A conversion start written while busy is ignored: no start pulse, and no change to the resolution or the channel. It sets the error bit, which stays set until the next write to offset 2.
- R7: A write to offset 2 loads the 8-bit control register, shown on `ctrl_q`, and clears the error bit. A write to offset 3 loads the gain from data bits 3:0, shown on `gain_q`.
- R8: For offsets 4, 5 and 6, `ctr_sel` is 0, 1 and 2. `ctr_wr` or `ctr_rd` follows the host strobe in the same cycle, `ctr_wdata` carries the host data, and a read returns `ctr_rdata` with `bus_oe` high.
- R9: A write to offset 7 raises `ctr_ctrl_wr` and no other strobe. A read of offset 7 drives 0x00 with `bus_oe` high and does not raise `ctr_rd`.
- R10: After reset, busy, error, result, channel, control and gain are all zero, and `adc_start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 10 | Host I/O address |
| bus_wdata | input | 8 | Host write data |
| bus_rd | input | 1 | Host read strobe, one access per cycle high |
| bus_wr | input | 1 | Host write strobe, one access per cycle high |
| bus_rdata | output | 8 | Host read data |
| bus_oe | output | 1 | Read data drive enable |
| base_sw | input | 7 | Window base switches (address bits 9:3) |
| adc_start | output | 1 | One-cycle conversion start pulse |
| adc_hi_res | output | 1 | Resolution of the current conversion, 1 = 12-bit |
| res_valid | input | 1 | Converter result valid |
| res_ready | output | 1 | Block accepts a result (high while busy) |
| res_data | input | 12 | Converter result |
| ctrl_q | output | 8 | Control register |
| gain_q | output | 4 | Gain register |
| ctr_sel | output | 2 | Counter index for counter accesses |
| ctr_wr | output | 1 | Counter load strobe |
| ctr_rd | output | 1 | Counter read strobe |
| ctr_ctrl_wr | output | 1 | Counter control write strobe |
| ctr_wdata | output | 8 | Data to the counter port |
| ctr_rdata | input | 8 | Data from the counter port |

## Verification
A stuck or lost busy flag shows up in the very next status read, at bit 7. It also shows on `res_ready` in the same cycle, either as a result accepted with no conversion outstanding or as a result refused while one is. A wrong error state shows at status bit 6 on the next read after a rejected start. Because the error is sticky, it stays visible until a control write clears it. A bad decode or a bad latched channel shows in the read data of the same cycle, or in the low byte read after the conversion completes.

// File: rtl/daq_regif_pkg.sv
package daq_regif_pkg;
  localparam int WIN_W = 3;
  typedef enum logic [WIN_W-1:0] {
    OFF_LO   = 3'd0,
    OFF_HI   = 3'd1,
    OFF_STAT = 3'd2,
    OFF_GAIN = 3'd3,
    OFF_C0   = 3'd4,
    OFF_C1   = 3'd5,
    OFF_C2   = 3'd6,
    OFF_CCTL = 3'd7
  } reg_off_e;
endpackage

// File: rtl/daq_win_decode.sv
module daq_win_decode
  import daq_regif_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic [AW-1:0]       addr,
  input  logic [AW-WIN_W-1:0] base_sw,
  input  logic                rd,
  input  logic                wr,
  output logic                hit,
  output reg_off_e            off,
  output logic                rd_hit,
  output logic                start_lo,
  output logic                start_hi,
  output logic                ld_ctrl,
  output logic                ld_gain,
  output logic                ctr_wr,
  output logic                ctr_rd,
  output logic                ctr_ctrl_wr
);
  logic wr_hit;

  always_comb begin
    hit         = (addr[AW-1:WIN_W] == base_sw);
    off         = reg_off_e'(addr[WIN_W-1:0]);
    wr_hit      = wr & hit;
    rd_hit      = rd & hit;
    start_lo    = 1'b0;
    start_hi    = 1'b0;
    ld_ctrl     = 1'b0;
    ld_gain     = 1'b0;
    ctr_wr      = 1'b0;
    ctr_rd      = 1'b0;
    ctr_ctrl_wr = 1'b0;
    case (off)
      OFF_LO:   start_lo = wr_hit;
      OFF_HI:   start_hi = wr_hit;
      OFF_STAT: ld_ctrl  = wr_hit;
      OFF_GAIN: ld_gain  = wr_hit;
      OFF_C0, OFF_C1, OFF_C2: begin
        ctr_wr = wr_hit;
        ctr_rd = rd_hit;
      end
      OFF_CCTL: ctr_ctrl_wr = wr_hit;
      default: ;
    endcase
  end
endmodule

// File: rtl/daq_conv_ctrl.sv
module daq_conv_ctrl #(
  parameter int RES_W    = 12,
  parameter int NARROW_W = 8,
  parameter int CHAN_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_lo,
  input  logic              start_hi,
  input  logic              clr_err,
  input  logic [CHAN_W-1:0] chan_in,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [RES_W-1:0]  res_data,
  output logic              adc_start,
  output logic              adc_hi_res,
  output logic              busy,
  output logic              err,
  output logic [RES_W-1:0]  result,
  output logic [CHAN_W-1:0] chan
);
  localparam int DROP_W = RES_W - NARROW_W;

  logic start_any;
  logic take;

  assign start_any = start_lo | start_hi;
  assign res_ready = busy;
  assign take      = res_valid & busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      err        <= 1'b0;
      adc_start  <= 1'b0;
      adc_hi_res <= 1'b0;
      result     <= '0;
      chan       <= '0;
    end else begin
      adc_start <= 1'b0;
      if (clr_err) err <= 1'b0;
      if (start_any) begin
        if (busy) begin
          err <= 1'b1;
        end else begin
          busy       <= 1'b1;
          adc_start  <= 1'b1;
          adc_hi_res <= start_hi;
          chan       <= chan_in;
        end
      end
      if (take) begin
        busy <= 1'b0;
        if (adc_hi_res) result <= res_data;
        else result <= {res_data[RES_W-1:DROP_W], {DROP_W{1'b0}}};
      end
    end
  end

  a_r6_err_on_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_any && busy) |=> err);
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !clr_err) |=> err);
  a_r6_no_pulse_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start_any && busy) |=> !adc_start);
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);
  a_r4_pulse_busy: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> busy);
  a_r5_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> !busy);
endmodule

// File: rtl/daq_rd_mux.sv
module daq_rd_mux
  import daq_regif_pkg::*;
#(
  parameter int DW     = 8,
  parameter int RES_W  = 12,
  parameter int CHAN_W = 4
) (
  input  logic              rd_hit,
  input  reg_off_e          off,
  input  logic [RES_W-1:0]  result,
  input  logic [CHAN_W-1:0] chan,
  input  logic              busy,
  input  logic              err,
  input  logic [DW-5:0]     ctrl_lo,
  input  logic [DW-5:0]     gain,
  input  logic [DW-1:0]     ctr_rdata,
  output logic [DW-1:0]     rdata,
  output logic              oe
);
  localparam int LO_RES_W = RES_W - DW;

  always_comb begin
    rdata = '0;
    oe    = rd_hit;
    if (rd_hit) begin
      case (off)
        OFF_LO:   rdata = {result[LO_RES_W-1:0], chan};
        OFF_HI:   rdata = result[RES_W-1:LO_RES_W];
        OFF_STAT: rdata = {busy, err, 2'b00, ctrl_lo};
        OFF_GAIN: rdata = {busy, err, 2'b00, gain};
        OFF_C0, OFF_C1, OFF_C2: rdata = ctr_rdata;
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/daq_regif.sv
module daq_regif
  import daq_regif_pkg::*;
#(
  parameter int AW    = 10,
  parameter int DW    = 8,
  parameter int RES_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  input  logic                bus_rd,
  input  logic                bus_wr,
  output logic [DW-1:0]       bus_rdata,
  output logic                bus_oe,
  input  logic [AW-WIN_W-1:0] base_sw,
  output logic                adc_start,
  output logic                adc_hi_res,
  input  logic                res_valid,
  output logic                res_ready,
  input  logic [RES_W-1:0]    res_data,
  output logic [DW-1:0]       ctrl_q,
  output logic [DW-5:0]       gain_q,
  output logic [1:0]          ctr_sel,
  output logic                ctr_wr,
  output logic                ctr_rd,
  output logic                ctr_ctrl_wr,
  output logic [DW-1:0]       ctr_wdata,
  input  logic [DW-1:0]       ctr_rdata
);
  localparam int FIELD_W = DW - 4;
  localparam int CHAN_W  = 2 * DW - RES_W;

  logic              hit, rd_hit;
  reg_off_e          off;
  logic              start_lo, start_hi, ld_ctrl, ld_gain;
  logic              busy, err;
  logic [RES_W-1:0]  result;
  logic [CHAN_W-1:0] chan;

  daq_win_decode #(.AW(AW)) u_dec (
    .addr(bus_addr), .base_sw(base_sw), .rd(bus_rd), .wr(bus_wr),
    .hit(hit), .off(off), .rd_hit(rd_hit),
    .start_lo(start_lo), .start_hi(start_hi),
    .ld_ctrl(ld_ctrl), .ld_gain(ld_gain),
    .ctr_wr(ctr_wr), .ctr_rd(ctr_rd), .ctr_ctrl_wr(ctr_ctrl_wr)
  );

  daq_conv_ctrl #(.RES_W(RES_W), .NARROW_W(DW), .CHAN_W(CHAN_W)) u_conv (
    .clk(clk), .rst_n(rst_n),
    .start_lo(start_lo), .start_hi(start_hi), .clr_err(ld_ctrl),
    .chan_in(ctrl_q[CHAN_W-1:0]),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .adc_start(adc_start), .adc_hi_res(adc_hi_res),
    .busy(busy), .err(err), .result(result), .chan(chan)
  );

  daq_rd_mux #(.DW(DW), .RES_W(RES_W), .CHAN_W(CHAN_W)) u_mux (
    .rd_hit(rd_hit), .off(off), .result(result), .chan(chan),
    .busy(busy), .err(err), .ctrl_lo(ctrl_q[FIELD_W-1:0]), .gain(gain_q),
    .ctr_rdata(ctr_rdata), .rdata(bus_rdata), .oe(bus_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      gain_q <= '0;
    end else begin
      if (ld_ctrl) ctrl_q <= bus_wdata;
      if (ld_gain) gain_q <= bus_wdata[FIELD_W-1:0];
    end
  end

  assign ctr_sel   = bus_addr[1:0];
  assign ctr_wdata = bus_wdata;

  a_r1_oe_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (bus_rd && bus_addr[AW-1:WIN_W] == base_sw));
  a_r1_no_strobe_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[AW-1:WIN_W] != base_sw) |-> !(ctr_wr || ctr_rd || ctr_ctrl_wr));
  a_r8_one_write_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctr_wr, ctr_ctrl_wr, ld_ctrl, ld_gain, start_lo, start_hi}));
  a_r7_gain_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_gain |=> $stable(gain_q));
  a_r7_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_ctrl |=> $stable(ctrl_q));
endmodule

// File: tb/daq_regif_tb.sv
`timescale 1ns/1ps
module daq_regif_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_rdata;
  logic        bus_oe;
  logic [6:0]  base_sw = 7'h60;
  logic        adc_start, adc_hi_res;
  logic        res_valid = 1'b0;
  logic        res_ready;
  logic [11:0] res_data = '0;
  logic [7:0]  ctrl_q;
  logic [3:0]  gain_q;
  logic [1:0]  ctr_sel;
  logic        ctr_wr, ctr_rd, ctr_ctrl_wr;
  logic [7:0]  ctr_wdata;
  logic [7:0]  ctr_rdata = '0;

  int checks = 0;
  int errors = 0;

  logic [7:0]  m_ctrl;
  logic [3:0]  m_gain, m_chan;
  logic        m_busy, m_err;
  logic [11:0] m_res;

  logic        s_wr, s_cw, s_rd;
  logic [1:0]  s_sel;
  logic [7:0]  s_wd;
  logic [7:0]  r_data;
  logic        r_oe;

  always #2.5 clk = ~clk;

  daq_regif u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata), .bus_oe(bus_oe),
    .base_sw(base_sw), .adc_start(adc_start), .adc_hi_res(adc_hi_res),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .ctrl_q(ctrl_q), .gain_q(gain_q), .ctr_sel(ctr_sel), .ctr_wr(ctr_wr),
    .ctr_rd(ctr_rd), .ctr_ctrl_wr(ctr_ctrl_wr), .ctr_wdata(ctr_wdata),
    .ctr_rdata(ctr_rdata)
  );

  function automatic logic [9:0] base_addr();
    return {base_sw, 3'b000};
  endfunction

  function automatic logic [7:0] exp_read(input int off);
    case (off)
      0: return {m_res[3:0], m_chan};
      1: return m_res[11:4];
      2: return {m_busy, m_err, 2'b00, m_ctrl[3:0]};
      3: return {m_busy, m_err, 2'b00, m_gain};
      4, 5, 6: return ctr_rdata;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [11:0] stored(input logic [11:0] d, input logic hi);
    return hi ? d : {d[11:4], 4'h0};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    #1;
    s_wr = ctr_wr; s_cw = ctr_ctrl_wr; s_sel = ctr_sel; s_wd = ctr_wdata;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [9:0] a);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    r_data = bus_rdata; r_oe = bus_oe; s_rd = ctr_rd; s_sel = ctr_sel;
    bus_rd = 1'b0;
  endtask

  task automatic read_chk(input string tag, input int off);
    bus_read(base_addr() + 10'(off));
    chk(tag, {7'd0, r_oe, r_data}, {7'd0, 1'b1, exp_read(off)});
  endtask

  task automatic start_conv(input logic hi);
    bus_write(base_addr() + (hi ? 10'd1 : 10'd0), 8'h00);
    #1;
    if (m_busy) begin
      chk("R6 start ignored while busy", {14'd0, adc_start, adc_hi_res}, {14'd0, 1'b0, m_res[0] ^ m_res[0] ^ adc_hi_res});
      m_err = 1'b1;
    end else begin
      chk("R4 start pulse and resolution", {14'd0, adc_start, adc_hi_res}, {14'd0, 1'b1, hi});
      m_busy = 1'b1; m_chan = m_ctrl[3:0];
    end
  endtask

  task automatic finish_conv(input logic [11:0] d, input logic hi);
    @(negedge clk);
    res_valid = 1'b1; res_data = d;
    #1;
    chk("R5 ready while busy", {15'd0, res_ready}, 16'd1);
    @(negedge clk);
    res_valid = 1'b0;
    m_busy = 1'b0; m_res = stored(d, hi);
  endtask

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED);
    m_ctrl = 0; m_gain = 0; m_chan = 0; m_busy = 0; m_err = 0; m_res = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R10 reset state
    for (int i = 0; i < 4; i++) read_chk("R10 reset register", i);
    chk("R10 reset outputs", {adc_start, res_ready, ctrl_q, gain_q}, 16'h0);

    // R1 outside window
    bus_read(10'h308);
    chk("R1 outside read", {7'd0, r_oe, r_data}, 16'h0);

    // R7 control and gain
    bus_write(10'h302, 8'hA5); m_ctrl = 8'hA5;
    chk("R7 ctrl_q", {8'd0, ctrl_q}, 16'h00A5);
    read_chk("R3 status", 2);
    bus_write(10'h303, 8'h3C); m_gain = 4'hC;
    chk("R7 gain_q", {12'd0, gain_q}, 16'h000C);
    read_chk("R3 gain read", 3);

    // R4 / R5 / R2 twelve-bit conversion
    start_conv(1'b1);
    read_chk("R3 busy in status", 2);
    chk("R4 pulse one cycle", {15'd0, adc_start}, 16'd0);
    finish_conv(12'hABC, 1'b1);
    read_chk("R2 low byte", 0);
    read_chk("R2 high byte", 1);
    read_chk("R5 busy cleared", 2);

    // R5 eight-bit conversion stores zero low nibble
    start_conv(1'b0);
    finish_conv(12'h123, 1'b0);
    read_chk("R5 narrow low byte", 0);
    read_chk("R5 narrow high byte", 1);

    // R6 start while busy
    start_conv(1'b1);
    start_conv(1'b0);
    read_chk("R6 error while busy", 2);
    finish_conv(12'h456, 1'b1);
    read_chk("R6 error sticky", 3);
    bus_write(10'h302, 8'h07); m_ctrl = 8'h07; m_err = 1'b0;
    read_chk("R6 error cleared by control write", 2);

    // R8 counter pass-through
    ctr_rdata = 8'h5A;
    bus_read(10'h305);
    chk("R8 counter read", {4'd0, s_rd, s_sel, r_oe, r_data}, {4'd0, 1'b1, 2'd1, 1'b1, 8'h5A});
    bus_write(10'h306, 8'h77);
    chk("R8 counter write", {5'd0, s_wr, s_cw, s_sel, s_wd}, {5'd0, 1'b1, 1'b0, 2'd2, 8'h77});

    // R9 counter control offset
    bus_write(10'h307, 8'h36);
    chk("R9 counter control write", {6'd0, s_wr, s_cw, s_wd}, {6'd0, 1'b0, 1'b1, 8'h36});
    bus_read(10'h307);
    chk("R9 offset 7 read", {7'd0, s_rd, r_oe, r_data}, {7'd0, 1'b0, 1'b1, 8'h00});

    // R1 relocated window
    base_sw = 7'h21;
    read_chk("R1 relocated status", 2);
    bus_read(10'h302);
    chk("R1 old window silent", {7'd0, r_oe, r_data}, 16'h0);
    bus_write(10'h302, 8'hFF);
    bus_write(10'h300, 8'h00);
    #1 chk("R1 outside write no start", {15'd0, adc_start}, 16'd0);
    read_chk("R1 outside write no effect", 2);
    base_sw = 7'h60;

    // constrained random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom % 5;
      case (op)
        0: begin
          logic [7:0] d;
          d = 8'($urandom);
          bus_write(base_addr() + 10'd2, d); m_ctrl = d; m_err = 1'b0;
          chk("R7 random ctrl", {8'd0, ctrl_q}, {8'd0, d});
        end
        1: begin
          logic [7:0] d;
          d = 8'($urandom);
          bus_write(base_addr() + 10'd3, d); m_gain = d[3:0];
          chk("R7 random gain", {12'd0, gain_q}, {12'd0, d[3:0]});
        end
        2: begin
          logic [9:0] a;
          a = 10'($urandom);
          if (a[9:3] == base_sw) a = a ^ 10'h200;
          bus_read(a);
          chk("R1 random outside read", {7'd0, r_oe, r_data}, 16'h0);
          bus_write(a, 8'($urandom));
          #1 chk("R1 random outside write", {15'd0, adc_start}, 16'd0);
        end
        3: begin
          logic hi;
          logic [11:0] d;
          hi = 1'($urandom);
          d = 12'($urandom);
          start_conv(hi);
          if (($urandom % 4) == 0) start_conv(~hi);
          repeat ($urandom % 3) @(negedge clk);
          #1 chk("R5 ready tracks busy", {15'd0, res_ready}, 16'd1);
          finish_conv(d, hi);
        end
        default: begin
          int off;
          off = $urandom % 4;
          read_chk("R2 R3 random read", off);
        end
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule